// File: doc/BRIEF.md
# Cursor Video and Output Skew Unit

This block produces the active-high cursor video bit for a character-based raster display and the final display-enable strobe. Each character clock it compares the live refresh memory address against the programmed cursor location and checks that the current raster row inside the character cell falls within the programmed cursor row window. A two-bit blink code chooses steady, hidden or one of two blink rates. The blink rates come from a field counter that steps once per field-start pulse.

Both the cursor bit and display-enable then pass through their own skew stage. Each stage can present its signal at once, one or two character clocks late, or hold it off entirely. This aligns them with the latency of refresh memory and the character generator. The timing generator supplies the addresses, display-enable and field pulse, and the register file supplies the configuration.

Top module: `crt_cursor_skew`

## Requirements
- R1: With the cursor steady (blink code 00), the undelayed cursor is high exactly when refresh_addr equals cursor_addr, start_cfg[4:0] <= raster_addr <= cursor_end, and de_in is high.
- R2: start_cfg bits 4:0 hold the cursor start raster and bits 6:5 hold the blink code. The blink bits take no part in the raster comparison.
- R3: Blink code 01 keeps cursor_out low under every other input.
- R4: The field counter resets to 0 and advances by one on each clock where field_pulse is high. With blink code 10 the cursor may show only while counter bits 3:0 are below 8, which gives 8 shown and 8 hidden fields in each 16.
- R5: With blink code 11 the cursor may show only while counter bits 4:0 are below 16, which gives 16 shown and 16 hidden fields in each 32.
- R6: The cursor is masked by the undelayed de_in, before any skew is applied.
- R7: The skew codes de_skew and cur_skew act independently. Code 00 presents the signal in the same cycle, 01 one clock later, and 10 two clocks later.
- R8: Skew code 11 holds the corresponding output low.
- R9: Reset clears both skew stages and the field counter. While reset is held, delayed outputs read low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| refresh_addr | input | 14 | Live refresh memory address |
| cursor_addr | input | 14 | Cursor location |
| raster_addr | input | 5 | Current raster row in the character cell |
| start_cfg | input | 7 | [4:0] cursor start raster, [6:5] blink code |
| cursor_end | input | 5 | Cursor end raster (inclusive) |
| field_pulse | input | 1 | One-clock pulse at each field start |
| de_in | input | 1 | Undelayed display-enable |
| de_skew | input | 2 | Display-enable skew code |
| cur_skew | input | 2 | Cursor skew code |
| de_out | output | 1 | Skewed display-enable |
| cursor_out | output | 1 | Skewed cursor video |

## Verification
The assertions check on every cycle that a held-off skew output stays low, that the cursor is silent while blink code 01 is set or while an unskewed de_in is low, and that the one- and two-clock taps reproduce earlier de_in values. The inclusive edges of the raster window, the exact field counts of the two blink rates, and the correct combination of these with independent skew settings show up only in the bench's scenarios. The bench checks them against a reference model of the field counter and the delay history.

// File: rtl/crt_cursor_skew.sv
module crt_cursor_skew #(
  parameter int ADDR_W  = 14,
  parameter int RA_W    = 5,
  parameter int BLINK_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] refresh_addr,
  input  logic [ADDR_W-1:0] cursor_addr,
  input  logic [RA_W-1:0]   raster_addr,
  input  logic [RA_W+1:0]   start_cfg,
  input  logic [RA_W-1:0]   cursor_end,
  input  logic              field_pulse,
  input  logic              de_in,
  input  logic [1:0]        de_skew,
  input  logic [1:0]        cur_skew,
  output logic              de_out,
  output logic              cursor_out
);
  localparam int FAST_BIT = BLINK_W - 2;
  localparam int SLOW_BIT = BLINK_W - 1;

  logic [BLINK_W-1:0] field_cnt;
  logic [1:0]         mode;
  logic [RA_W-1:0]    start_row;
  logic               in_window, blink_on, cur_raw;
  logic [1:0]         d1, d2, raw, sel0, sel1;

  assign start_row = start_cfg[RA_W-1:0];
  assign mode      = start_cfg[RA_W+1:RA_W];
  assign in_window = (refresh_addr == cursor_addr) &&
                     (raster_addr >= start_row) && (raster_addr <= cursor_end);

  always_comb begin
    case (mode)
      2'b00:   blink_on = 1'b1;
      2'b01:   blink_on = 1'b0;
      2'b10:   blink_on = ~field_cnt[FAST_BIT];
      default: blink_on = ~field_cnt[SLOW_BIT];
    endcase
  end

  assign cur_raw = in_window && blink_on && de_in;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)           field_cnt <= '0;
    else if (field_pulse) field_cnt <= field_cnt + 1'b1;

  assign raw  = {cur_raw, de_in};
  assign sel0 = {cur_skew[0], de_skew[0]};
  assign sel1 = {cur_skew[1], de_skew[1]};

  logic [1:0] tap;
  for (genvar i = 0; i < 2; i++) begin : g_skew
    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        d1[i] <= 1'b0;
        d2[i] <= 1'b0;
      end else begin
        d1[i] <= raw[i];
        d2[i] <= d1[i];
      end
    always_comb begin
      case ({sel1[i], sel0[i]})
        2'b00:   tap[i] = raw[i];
        2'b01:   tap[i] = d1[i];
        2'b10:   tap[i] = d2[i];
        default: tap[i] = 1'b0;
      endcase
    end
  end

  assign de_out     = tap[0];
  assign cursor_out = tap[1];
endmodule

// File: rtl/crt_cursor_skew_chk.sv
module crt_cursor_skew_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [6:0] start_cfg,
  input logic       de_in,
  input logic [1:0] de_skew,
  input logic [1:0] cur_skew,
  input logic       de_out,
  input logic       cursor_out
);
  logic [1:0] age;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;

  AST_DE_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    de_skew == 2'b11 |-> !de_out); // R8
  AST_CUR_HELD_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    cur_skew == 2'b11 |-> !cursor_out); // R8
  AST_NEVER_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (start_cfg[6:5] == 2'b01 && cur_skew == 2'b00) |-> !cursor_out); // R3
  AST_MASKED_BY_DE: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_skew == 2'b00 && !de_in) |-> !cursor_out); // R6
  AST_DE_ONE_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd1 && de_skew == 2'b01) |-> de_out == $past(de_in)); // R7
  AST_DE_TWO_LATE: assert property (@(posedge clk) disable iff (!rst_n)
    (age >= 2'd2 && de_skew == 2'b10) |-> de_out == $past(de_in, 2)); // R7
endmodule

bind crt_cursor_skew crt_cursor_skew_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_cfg(start_cfg), .de_in(de_in),
  .de_skew(de_skew), .cur_skew(cur_skew), .de_out(de_out), .cursor_out(cursor_out)
);

// File: tb/crt_cursor_skew_tb_top.sv
module crt_cursor_skew_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [13:0] refresh_addr = '0, cursor_addr = '0;
  logic [4:0]  raster_addr = '0, cursor_end = '0;
  logic [6:0]  start_cfg = '0;
  logic        field_pulse = 1'b0, de_in = 1'b0;
  logic [1:0]  de_skew = '0, cur_skew = '0;
  logic        de_out, cursor_out;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [4:0] m_cnt = '0;
  logic h_de1 = 0, h_de2 = 0, h_cu1 = 0, h_cu2 = 0;

  always #2 clk = ~clk;

  crt_cursor_skew dut_i (.*);

  function automatic logic f_raw_cur(logic [4:0] cnt);
    logic vis;
    case (start_cfg[6:5])
      2'b00: vis = 1'b1;
      2'b01: vis = 1'b0;
      2'b10: vis = (cnt[3:0] < 4'd8);
      default: vis = (cnt < 5'd16);
    endcase
    return vis && de_in && refresh_addr == cursor_addr &&
           raster_addr >= start_cfg[4:0] && raster_addr <= cursor_end;
  endfunction

  function automatic logic f_tap(logic [1:0] code, logic a, logic b, logic c);
    case (code)
      2'b00: return a;
      2'b01: return b;
      2'b10: return c;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string tag, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %0b expected %0b at %0t", tag, got, exp, $time);
    end
  endtask

  // call right after the negedge once the inputs are set
  task automatic evaluate(string tag);
    logic raw;
    string ct;
    #1;
    raw = f_raw_cur(m_cnt);
    ct = (cur_skew == 2'b11) ? "R8" :
         (start_cfg[6:5] == 2'b01) ? "R3" :
         (start_cfg[6:5] == 2'b10) ? "R4" :
         (start_cfg[6:5] == 2'b11) ? "R5" : "R1";
    check((tag != "") ? tag : ((de_skew == 2'b11) ? "R8" : "R7"),
          de_out, f_tap(de_skew, de_in, h_de1, h_de2));
    check((tag != "") ? tag : ct, cursor_out, f_tap(cur_skew, raw, h_cu1, h_cu2));
    if (rst_n) begin
      h_de2 = h_de1; h_de1 = de_in;
      h_cu2 = h_cu1; h_cu1 = raw;
      if (field_pulse) m_cnt = m_cnt + 1'b1;
    end
  endtask

  initial begin
    #800000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    // R9: reset state, delayed taps low while de_in and cursor would be high
    @(negedge clk);
    de_in = 1; cursor_addr = 14'h0123; refresh_addr = 14'h0123;
    cursor_end = 5'd7; start_cfg = 7'd0; de_skew = 2'b01; cur_skew = 2'b10;
    evaluate("R9");
    @(negedge clk); de_skew = 2'b10; cur_skew = 2'b01; evaluate("R9");
    @(negedge clk); rst_n = 1; de_skew = 2'b00; cur_skew = 2'b00; raster_addr = 5'd0;
    evaluate("R1");

    // R2: raster window edges with blink bits present only in mode field
    start_cfg = {2'b00, 5'd3}; cursor_end = 5'd6;
    for (int r = 0; r < 9; r++) begin
      @(negedge clk); raster_addr = r[4:0]; evaluate("R2");
    end
    // R6: masking by undelayed de_in, cursor skew 1 and de skew 0
    @(negedge clk); raster_addr = 5'd4; de_in = 0; cur_skew = 2'b01; evaluate("R6");
    @(negedge clk); de_in = 1; evaluate("R6");
    @(negedge clk); evaluate("R6");

    // R4 / R5: blink sweeps over full periods
    cur_skew = 2'b00;
    for (int md = 2; md < 4; md++) begin
      @(negedge clk); start_cfg = {md[1:0], 5'd0}; raster_addr = 5'd0; field_pulse = 0;
      evaluate("");
      for (int f = 0; f < 70; f++) begin
        @(negedge clk); field_pulse = 1; evaluate(md == 2 ? "R4" : "R5");
      end
      @(negedge clk); field_pulse = 0; evaluate("");
    end

    // randomized mix, R7 / R8 with independent skews
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      cursor_addr  = 14'($urandom_range(0, 15));
      refresh_addr = ($urandom_range(0, 1) == 0) ? cursor_addr : 14'($urandom_range(0, 15));
      raster_addr  = 5'($urandom_range(0, 31));
      start_cfg    = {2'($urandom_range(0, 3)), 5'($urandom_range(0, 12))};
      cursor_end   = 5'($urandom_range(8, 31));
      de_in        = ($urandom_range(0, 3) != 0);
      field_pulse  = ($urandom_range(0, 3) == 0);
      if ($urandom_range(0, 15) == 0) begin
        de_skew  = 2'($urandom_range(0, 3));
        cur_skew = 2'($urandom_range(0, 3));
      end
      evaluate("");
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule